// File: doc/BRIEF.md
# Pipelined Fixed-Point Harris Corner Scorer

This block scores one 5x5 grayscale window per clock with the Harris corner measure for the window's centre pixel. Every pixel of the centre's 3x3 neighbourhood gets a horizontal and a vertical gradient from three-pixel row and column sums. The squared and cross gradient products of all nine pixels are weighted with an integer Gaussian kernel scaled by 1024. The weighted sums form a 2x2 structure tensor. The response is the tensor determinant minus a fixed-point fraction (51/1024) of the squared trace.

A window source, such as a line-buffered sliding window, presents the 25 pixels together with a valid bit and an opaque tag. After a fixed latency, the block returns the signed response, a strong-corner flag and the same tag. The flag compares the response against a threshold given at a port. All arithmetic is integer. Each weighted product is truncated before it is summed, which keeps the adders narrow.

Top module: `harris_resp`

## Requirements
- R1: The window pixel at row r, column c (row 0 at the top, column 0 at the left) sits at `win_i[(5*r+c)*8 +: 8]`. For each neighbourhood pixel (r,c) with r,c in 1..3, Ix = |sum of column c+1 over rows r-1..r+1 − sum of column c-1 over the same rows| and Iy = |sum of row r+1 over columns c-1..c+1 − sum of row r-1 over the same columns|.
- R2: The three products Ix·Ix, Iy·Iy and Ix·Iy are formed for all nine neighbourhood pixels.
- R3: Each product is multiplied by its kernel weight and then shifted right by 10 (floor) before any summing. The weight is 158 at the centre, 122 where exactly one offset is zero, and 95 at the four diagonal positions.
- R4: Each tensor component (gxx, gyy, gxy) is the sum of its nine truncated weighted terms, formed as three row sums and then their total.
- R5: resp_o = gxx·gyy − gxy² − floor(51·(gxx+gyy)²/1024), as a signed 48-bit value.
- R6: corner_o is 1 exactly when resp_o > thresh_i, with both treated as signed. The threshold used is the value present at the clock edge that registers the result.
- R7: One window is accepted per clock. Its result, valid_o and tag_o appear after the 8th rising edge, counting the edge that accepted the window.
- R8: A synchronous reset drives valid_o, corner_o, resp_o and tag_o to 0 and drops every window still in flight.
- R9: Maximum-contrast windows (0/255 checkerboards and steps) give exact results with no overflow.
- R10: A clock with valid_i low yields valid_o low in the matching output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Window present this cycle |
| win_i | input | 200 | 25 packed 8-bit pixels, row-major from the top-left |
| tag_i | input | 8 | Sideband tag carried alongside the window |
| thresh_i | input | 48 | Signed strong-corner threshold |
| valid_o | output | 1 | Result present |
| tag_o | output | 8 | Tag of the window that produced the result |
| resp_o | output | 48 | Signed Harris response |
| corner_o | output | 1 | Response strictly above threshold |

## Verification
A wrong gradient, product, weight or truncation shows up as a response that differs from an integer model using the same rounding order. The difference appears in the output slot exactly eight edges after the window. Flat windows must give exactly zero, and pure edges must give a non-positive response, so a sign or ordering error is exposed at once. A fault in the valid or tag delay appears as an extra, missing or mislabelled result in that same slot. The threshold compare is probed at R and R−1 to catch an off-by-one in the strict comparison.

// File: rtl/harris_pkg.sv
`timescale 1ns/1ps
package harris_pkg;
  localparam int WIN      = 5;   // window edge
  localparam int NB       = 9;   // neighbourhood pixels
  localparam int GSHIFT   = 10;  // kernel scale 2^10
  localparam int KNUM     = 51;  // k ~ 51/1024
  localparam int KSHIFT   = 10;
  localparam int LAT      = 8;   // register stages, input edge to output
  localparam int W_DIAG   = 95;
  localparam int W_AXIS   = 122;
  localparam int W_MID    = 158;

  function automatic int gauss_w(input int dr, input int dc);
    if (dr == 0 && dc == 0)      return W_MID;
    else if (dr == 0 || dc == 0) return W_AXIS;
    else                         return W_DIAG;
  endfunction
endpackage

// File: rtl/hr_grad.sv
`timescale 1ns/1ps
// Stages 1-2: neighbour sums, then absolute gradients for one pixel.
module hr_grad import harris_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + 2,
  parameter int ROW   = 2,
  parameter int COL   = 2
) (
  input  logic                       clk,
  input  logic [WIN*WIN*PIX_W-1:0]   win_i,
  output logic [SUM_W-1:0]           ix_o,
  output logic [SUM_W-1:0]           iy_o
);
  logic [SUM_W-1:0] s_rt, s_lf, s_up, s_dn;
  logic [SUM_W-1:0] rt_q, lf_q, up_q, dn_q;

  always_comb begin
    s_rt = '0; s_lf = '0; s_up = '0; s_dn = '0;
    for (int k = -1; k <= 1; k++) begin
      s_rt = s_rt + SUM_W'(win_i[((ROW+k)*WIN + COL+1)*PIX_W +: PIX_W]);
      s_lf = s_lf + SUM_W'(win_i[((ROW+k)*WIN + COL-1)*PIX_W +: PIX_W]);
      s_up = s_up + SUM_W'(win_i[((ROW-1)*WIN + COL+k)*PIX_W +: PIX_W]);
      s_dn = s_dn + SUM_W'(win_i[((ROW+1)*WIN + COL+k)*PIX_W +: PIX_W]);
    end
  end

  always_ff @(posedge clk) begin
    rt_q <= s_rt;
    lf_q <= s_lf;
    up_q <= s_up;
    dn_q <= s_dn;
    ix_o <= (rt_q >= lf_q) ? rt_q - lf_q : lf_q - rt_q;
    iy_o <= (dn_q >= up_q) ? dn_q - up_q : up_q - dn_q;
  end
endmodule

// File: rtl/hr_tensor.sv
`timescale 1ns/1ps
// Stages 3-4: gradient products, then kernel weight with early truncation.
module hr_tensor import harris_pkg::*; #(
  parameter int DER_W  = 10,
  parameter int SQ_W   = 2 * DER_W,
  parameter int WT_W   = SQ_W + 8,
  parameter int TERM_W = WT_W - GSHIFT,
  parameter int WGT    = W_MID
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DER_W-1:0]  ix_i,
  input  logic [DER_W-1:0]  iy_i,
  output logic [TERM_W-1:0] txx_o,
  output logic [TERM_W-1:0] tyy_o,
  output logic [TERM_W-1:0] txy_o
);
  logic [SQ_W-1:0] xx_q, yy_q, xy_q;
  logic [WT_W-1:0] wxx, wyy, wxy;

  always_ff @(posedge clk) begin
    xx_q <= SQ_W'(ix_i) * SQ_W'(ix_i);
    yy_q <= SQ_W'(iy_i) * SQ_W'(iy_i);
    xy_q <= SQ_W'(ix_i) * SQ_W'(iy_i);
  end

  always_comb begin
    wxx = WT_W'(xx_q) * WT_W'(WGT);
    wyy = WT_W'(yy_q) * WT_W'(WGT);
    wxy = WT_W'(xy_q) * WT_W'(WGT);
  end

  always_ff @(posedge clk) begin
    txx_o <= wxx[WT_W-1:GSHIFT];
    tyy_o <= wyy[WT_W-1:GSHIFT];
    txy_o <= wxy[WT_W-1:GSHIFT];
  end

  // R2: a cross product never exceeds the larger square
  p_cross_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (xy_q <= xx_q) || (xy_q <= yy_q));
endmodule

// File: rtl/hr_smooth.sv
`timescale 1ns/1ps
// Stages 5-6: row sums of weighted terms, then component totals.
module hr_smooth import harris_pkg::*; #(
  parameter int TERM_W = 18,
  parameter int ROW_W  = TERM_W + 2,
  parameter int G_W    = TERM_W + 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [2:0][NB-1:0][TERM_W-1:0]     t_i,
  output logic [2:0][G_W-1:0]                g_o
);
  logic [2:0][2:0][ROW_W-1:0] r_q;

  always_ff @(posedge clk) begin
    for (int m = 0; m < 3; m++) begin
      for (int r = 0; r < 3; r++) begin
        r_q[m][r] <= ROW_W'(t_i[m][3*r]) + ROW_W'(t_i[m][3*r+1])
                   + ROW_W'(t_i[m][3*r+2]);
      end
      g_o[m] <= G_W'(r_q[m][0]) + G_W'(r_q[m][1]) + G_W'(r_q[m][2]);
    end
  end

  // R4: the total of a component covers each of its row sums
  p_sum_cover_r4: assert property (@(posedge clk) disable iff (rst)
    g_o[0] >= G_W'($past(r_q[0][1])));
endmodule

// File: rtl/hr_score.sv
`timescale 1ns/1ps
// Stages 7-8: determinant and scaled trace, then response and flag.
module hr_score import harris_pkg::*; #(
  parameter int G_W    = 22,
  parameter int RESP_W = 48,
  parameter int EXT_W  = (2*G_W + 8 > RESP_W) ? 2*G_W + 8 : RESP_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0][G_W-1:0]      g_i,
  input  logic signed [RESP_W-1:0] thresh_i,
  output logic signed [RESP_W-1:0] resp_o,
  output logic                     corner_o
);
  logic signed [EXT_W-1:0] a, b, c, tr, det_d, ktr_d;
  logic signed [EXT_W-1:0] det_q, ktr_q, diff, th_ext;

  always_comb begin
    a     = $signed(EXT_W'(g_i[0]));
    b     = $signed(EXT_W'(g_i[1]));
    c     = $signed(EXT_W'(g_i[2]));
    tr    = a + b;
    det_d = a * b - c * c;
    ktr_d = (tr * tr * $signed(EXT_W'(KNUM))) >>> KSHIFT;
  end

  always_ff @(posedge clk) begin
    det_q <= det_d;
    ktr_q <= ktr_d;
  end

  always_comb begin
    diff   = det_q - ktr_q;
    th_ext = {{(EXT_W-RESP_W){thresh_i[RESP_W-1]}}, thresh_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_o   <= '0;
      corner_o <= 1'b0;
    end else begin
      resp_o   <= diff[RESP_W-1:0];
      corner_o <= diff > th_ext;
    end
  end

  // R6: a raised flag implies the registered response beat the threshold
  p_flag_above_r6: assert property (@(posedge clk) disable iff (rst)
    corner_o |-> (resp_o > $past(thresh_i)));
  // R5: the subtracted trace term is never negative
  p_ktr_sign_r5: assert property (@(posedge clk) disable iff (rst)
    !ktr_q[EXT_W-1]);
endmodule

// File: rtl/harris_resp.sv
`timescale 1ns/1ps
module harris_resp import harris_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int TAG_W  = 8,
  parameter int RESP_W = 48
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      valid_i,
  input  logic [WIN*WIN*PIX_W-1:0]  win_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic signed [RESP_W-1:0]  thresh_i,
  output logic                      valid_o,
  output logic [TAG_W-1:0]          tag_o,
  output logic signed [RESP_W-1:0]  resp_o,
  output logic                      corner_o
);
  localparam int DER_W  = PIX_W + 2;
  localparam int SQ_W   = 2 * DER_W;
  localparam int WT_W   = SQ_W + 8;
  localparam int TERM_W = WT_W - GSHIFT;
  localparam int G_W    = TERM_W + 4;

  logic [NB-1:0][DER_W-1:0]          ix, iy;
  logic [2:0][NB-1:0][TERM_W-1:0]    terms;
  logic [2:0][G_W-1:0]               gsum;

  for (genvar gr = 0; gr < 3; gr++) begin : g_row
    for (genvar gc = 0; gc < 3; gc++) begin : g_col
      localparam int N = gr*3 + gc;
      hr_grad #(.PIX_W(PIX_W), .SUM_W(DER_W), .ROW(gr+1), .COL(gc+1)) u_grad (
        .clk(clk), .win_i(win_i), .ix_o(ix[N]), .iy_o(iy[N]));
      hr_tensor #(.DER_W(DER_W), .SQ_W(SQ_W), .WT_W(WT_W), .TERM_W(TERM_W),
                  .WGT(gauss_w(gr-1, gc-1))) u_tens (
        .clk(clk), .rst(rst), .ix_i(ix[N]), .iy_i(iy[N]),
        .txx_o(terms[0][N]), .tyy_o(terms[1][N]), .txy_o(terms[2][N]));
    end
  end

  hr_smooth #(.TERM_W(TERM_W), .ROW_W(TERM_W+2), .G_W(G_W)) u_smooth (
    .clk(clk), .rst(rst), .t_i(terms), .g_o(gsum));

  hr_score #(.G_W(G_W), .RESP_W(RESP_W)) u_score (
    .clk(clk), .rst(rst), .g_i(gsum), .thresh_i(thresh_i),
    .resp_o(resp_o), .corner_o(corner_o));

  // valid and tag travel through LAT matching stages
  logic [LAT-1:0]            v_q;
  logic [LAT-1:0][TAG_W-1:0] t_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      t_q <= '0;
    end else begin
      v_q <= {v_q[LAT-2:0], valid_i};
      t_q <= {t_q[LAT-2:0], tag_i};
    end
  end

  assign valid_o = v_q[LAT-1];
  assign tag_o   = t_q[LAT-1];

  // cycles since reset, saturating at LAT, to bound the $past window
  logic [3:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst)                   seen_q <= '0;
    else if (seen_q != 4'(LAT)) seen_q <= seen_q + 4'd1;
  end

  // R7: output valid and tag are the inputs from LAT edges earlier
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
    (seen_q == 4'(LAT)) |-> (valid_o == $past(valid_i, LAT)));
  p_tag_lat_r7: assert property (@(posedge clk) disable iff (rst)
    (seen_q == 4'(LAT) && valid_o) |-> (tag_o == $past(tag_i, LAT)));
  // R8: the cycle after reset shows no result
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && !corner_o && resp_o == '0));
endmodule

// File: tb/sim_harris_resp.sv
`timescale 1ns/1ps
module sim_harris_resp;
  localparam int LATB = 8;
  localparam int WB   = 200;

  logic               clk = 1'b0;
  logic               rst, valid_i, valid_o, corner_o;
  logic [WB-1:0]      win_i;
  logic [7:0]         tag_i, tag_o;
  logic signed [47:0] thresh_i, resp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  harris_resp u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .win_i(win_i), .tag_i(tag_i),
    .thresh_i(thresh_i), .valid_o(valid_o), .tag_o(tag_o),
    .resp_o(resp_o), .corner_o(corner_o));

  // ---------------- integer reference model ----------------
  function automatic longint px(input logic [WB-1:0] w, input int r, input int c);
    return longint'(w[(r*5+c)*8 +: 8]);
  endfunction

  function automatic longint href(input logic [WB-1:0] w);
    longint gxx = 0, gyy = 0, gxy = 0, det, tr;
    for (int r = 1; r <= 3; r++) begin
      for (int c = 1; c <= 3; c++) begin
        longint sr = 0, sl = 0, su = 0, sd = 0, ix, iy, wt;
        for (int k = -1; k <= 1; k++) begin
          sr += px(w, r+k, c+1); sl += px(w, r+k, c-1);
          su += px(w, r-1, c+k); sd += px(w, r+1, c+k);
        end
        ix = (sr > sl) ? sr - sl : sl - sr;
        iy = (sd > su) ? sd - su : su - sd;
        wt = (r == 2 && c == 2) ? 158 : ((r == 2 || c == 2) ? 122 : 95);
        gxx += (ix*ix*wt) >>> 10;
        gyy += (iy*iy*wt) >>> 10;
        gxy += (ix*iy*wt) >>> 10;
      end
    end
    det = gxx*gyy - gxy*gxy;
    tr  = gxx + gyy;
    return det - ((tr*tr*51) >>> 10);
  endfunction

  // pattern kinds: 0 flat, 1 vertical step, 2 horizontal step,
  // 3 bright top-left quadrant, 4 checkerboard, 5 random, 6 ramp, 7 centre spot
  function automatic logic [WB-1:0] mk(input int kind, input int p);
    logic [WB-1:0] w;
    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < 5; c++) begin
        int v;
        case (kind)
          0: v = p;
          1: v = (c >= 2) ? p : 0;
          2: v = (r >= 3) ? p : 0;
          3: v = (r <= 2 && c <= 2) ? p : 0;
          4: v = ((r + c) % 2 == 0) ? p : 0;
          5: v = int'($urandom_range(255, 0));
          6: v = (c * p + r * 7) % 256;
          default: v = (r == 2 && c == 2) ? p : 0;
        endcase
        w[(r*5+c)*8 +: 8] = 8'(v);
      end
    end
    return w;
  endfunction

  localparam logic [15:0] PATS [14] = '{
    {8'd0, 8'd0},   {8'd0, 8'd255}, {8'd1, 8'd255}, {8'd2, 8'd255},
    {8'd3, 8'd255}, {8'd3, 8'd90},  {8'd4, 8'd255}, {8'd4, 8'd17},
    {8'd5, 8'd0},   {8'd5, 8'd1},   {8'd6, 8'd40},  {8'd6, 8'd3},
    {8'd7, 8'd255}, {8'd1, 8'd1}
  };

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  bit         pv [LATB];
  longint     pr [LATB];
  logic [7:0] pt [LATB];
  initial for (int i = 0; i < LATB; i++) begin pv[i] = 0; pr[i] = 0; pt[i] = 0; end

  // model the pipeline from inputs stable at the edge; compare 5 ns later
  always @(posedge clk) begin
    longint th_now;
    th_now = longint'(thresh_i);
    if (rst) begin
      for (int i = 0; i < LATB; i++) begin pv[i] = 0; pr[i] = 0; pt[i] = 0; end
    end else begin
      for (int i = LATB-1; i > 0; i--) begin
        pv[i] = pv[i-1]; pr[i] = pr[i-1]; pt[i] = pt[i-1];
      end
      pv[0] = valid_i;
      pr[0] = href(win_i);
      pt[0] = tag_i;
    end
    #5;
    chk(valid_o == pv[LATB-1], "R7 R10", "valid_o slot",
        longint'(valid_o), longint'(pv[LATB-1]));
    if (pv[LATB-1]) begin
      chk(longint'(resp_o) == pr[LATB-1], "R1 R2 R3 R4 R5 R9", "resp_o",
          longint'(resp_o), pr[LATB-1]);
      chk(corner_o == (pr[LATB-1] > th_now), "R6", "corner_o",
          longint'(corner_o), longint'(pr[LATB-1] > th_now));
      chk(tag_o == pt[LATB-1], "R7", "tag_o",
          longint'(tag_o), longint'(pt[LATB-1]));
    end
  end

  task automatic push(input logic [WB-1:0] w, input bit v);
    @(negedge clk);
    win_i   = w;
    valid_i = v;
    tag_i   = tag_i + 8'd1;
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) push('0, 1'b0);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    longint r;
    logic [WB-1:0] w;
    void'($urandom(7));
    rst = 1'b1; valid_i = 1'b1; win_i = mk(4, 255); tag_i = 8'hA5;
    thresh_i = 48'sd10000;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(valid_o == 1'b0, "R8", "valid_o in reset", longint'(valid_o), 0);
    chk(corner_o == 1'b0, "R8", "corner_o in reset", longint'(corner_o), 0);
    chk(resp_o == '0, "R8", "resp_o in reset", longint'(resp_o), 0);
    chk(tag_o == '0, "R8", "tag_o in reset", longint'(tag_o), 0);
    rst = 1'b0; valid_i = 1'b0;

    // table of patterns, back to back (R7 throughput, R9 extremes)
    foreach (PATS[i]) push(mk(int'(PATS[i][15:8]), int'(PATS[i][7:0])), 1'b1);
    flush(10);

    // hand-derived expectations (R5): flat gives 0, pure edge gives <= 0
    chk(href(mk(0, 200)) == 0, "R5", "model flat", href(mk(0, 200)), 0);
    chk(href(mk(1, 255)) <= 0, "R5", "model edge sign", href(mk(1, 255)), 0);

    // random stream with gaps (R10)
    for (int i = 0; i < 160; i++) push(mk(5, 0), ($urandom_range(3, 0) != 0));
    flush(10);

    // threshold boundary (R6): equal is not a corner, one below is
    w = mk(3, 200);
    r = href(w);
    @(negedge clk); thresh_i = 48'(r);
    push(w, 1'b1); flush(10);
    @(negedge clk); thresh_i = 48'(r - 1);
    push(w, 1'b1); flush(10);
    @(negedge clk); thresh_i = -48'sd1;
    push(mk(0, 33), 1'b1); flush(10);
    @(negedge clk); thresh_i = 48'sd10000;

    // reset in mid-stream drops in-flight windows (R8)
    for (int i = 0; i < 5; i++) push(mk(5, 0), 1'b1);
    @(negedge clk); rst = 1'b1; valid_i = 1'b0;
    @(negedge clk); rst = 1'b0;
    chk(valid_o == 1'b0 && resp_o == '0, "R8", "outputs after mid reset",
        longint'(resp_o), 0);
    flush(12);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule